// File: doc/BRIEF.md
# Serial Register Port with Shared Data-Ready Output

This block is the digital serial front end of a converter and acts as a slave on a four-wire serial bus. The wires are active-low select, serial clock, data in and one shared output. Every access begins with an 8-bit command byte. The command byte names a target register and says whether the access reads or writes it. Then the contents of the named register are shifted in or out. Between accesses the shared output carries a ready flag. The flag drops when the converter delivers a new result. It goes high again after the result has been read, or when the converter warns that the next update is imminent.

A one-cycle `conv_done` strobe with a result word stands in for the converter. A one-cycle `pre_update` strobe marks the moment just before the next update. The mode and configuration words are presented at ports so that the converter can use them.

All serial inputs are synchronised to the system clock. Edges of the serial clock are found by comparing the synchronised value with its previous value. The serial clock must therefore stay at least a few system clocks in each phase.

Top module: `adc_serial_if`

## Requirements
- R1: While select is high, `dout_oe` is 0. Raising select also abandons any partial transfer, so that the next low period starts with a fresh command byte.
- R2: The command byte is captured MSB first on rising serial clock edges. Bit 6 = 1 means read. Bits 5:3 give the register address. Bit 2 requests continuous read. Bits 7, 1 and 0 must be 0; otherwise the whole byte is ignored.
- R3: Read data is driven MSB first and changes on falling serial clock edges, so that the host samples it on the rising edge.
- R4: The register widths and addresses are: 0 = status (read, 8 bits), 1 = mode (16 bits), 2 = configuration (16 bits), 3 = result (DW bits, read-only), 4 = identity (8 bits, read-only, value ID_VALUE), 5 to 7 = read as 8 zero bits. A write command to address 0 has no data phase.
- R5: Writes to mode and configuration are stored, can be read back, and appear on `mode_word` and `cfg_word`. The update-rate code is in bits 3:0 of `mode_word` and the clock-source code in bits 7:6. Writes to a read-only address consume their bits and change nothing.
- R6: A `conv_done` strobe stores `conv_result` unchanged and makes the ready flag 0 on the next cycle. While select is low and no read is shifting, `dout` shows the ready flag.
- R7: A `pre_update` strobe sets the ready flag back to 1 unless `conv_done` arrives in the same cycle, in which case `conv_done` wins.
- R8: Completing a full read of the result register sets the ready flag to 1. A later read returns the same word while no new result arrives.
- R9: Status bit 7 is the ready flag (0 = unread result). Bit 0 is 1 when DW is 24. All other status bits are 0.
- R10: A read command to address 3 with bit 2 set enters continuous read and has no data phase. From then on, each time the flag is 0, DW clocks shift the result out with no command byte, and each result is delivered only once. While the flag is 1, clocks shift out ones and commands are not decoded.
- R11: Thirty-two consecutive ones captured on data in return the port to waiting for a command byte and leave continuous read. Stored registers are unchanged.
- R12: The result register is DW bits wide (16 or 24). Its code is passed through untouched, so an offset-binary word reads back bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, idle high |
| din | input | 1 | Serial data in |
| conv_done | input | 1 | One-cycle strobe: new result on `conv_result` |
| conv_result | input | DW | Converter result word |
| pre_update | input | 1 | One-cycle strobe: next update is imminent |
| dout | output | 1 | Shared serial data out / ready flag |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| mode_word | output | 16 | Stored mode register |
| cfg_word | output | 16 | Stored configuration register |

## Verification
The bound checker watches the ready flag on every cycle. It checks that the flag falls the cycle after each result strobe. It checks that a warning strobe alone raises the flag. It checks that every rise and fall of the flag is traced back to a legal cause. It also checks that a deselected port always sits waiting for a command, and that the ones counter stays below its limit.

Only the bench's scenarios can show the rest. These are the serial bit ordering and the register contents read back, which writes are discarded, the one-shot nature of continuous read, and recovery after an aborted frame or a run of thirty-two ones.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
    typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

    localparam logic [2:0] A_COMM = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_CFG  = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_ID   = 3'd4;

    localparam int SHW         = 24;
    localparam int RESYNC_ONES = 32;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/sif_ready.sv
module sif_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic pre_update,
    input  logic read_done,
    output logic rdy_n
);
    logic rdy_n_d, rdy_n_q;

    always_comb begin
        rdy_n_d = rdy_n_q;
        if (conv_done)                    rdy_n_d = 1'b0;
        else if (pre_update || read_done) rdy_n_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_n_q <= 1'b1;
        else        rdy_n_q <= rdy_n_d;
    end

    assign rdy_n = rdy_n_q;
endmodule

// File: rtl/sif_resync.sv
module sif_resync #(
    parameter int ONES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rise,
    input  logic bit_in,
    output logic hit,
    output logic [$clog2(ONES+1)-1:0] cnt
);
    localparam int CW = $clog2(ONES + 1);
    localparam logic [CW-1:0] LAST = CW'(ONES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = active && rise && bit_in && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!active)      cnt_d = '0;
        else if (rise)    cnt_d = (bit_in && !hit) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
    import adc_sif_pkg::*;
#(
    parameter int         DW       = 24,
    parameter logic [7:0] ID_VALUE = 8'h5A,
    parameter logic [15:0] MODE_RST = 16'h000A,
    parameter logic [15:0] CFG_RST  = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          din,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_result,
    input  logic          pre_update,
    output logic          dout,
    output logic          dout_oe,
    output logic [15:0]   mode_word,
    output logic [15:0]   cfg_word
);
    localparam logic [4:0] LEN_DATA = 5'(DW);
    localparam int         CW       = $clog2(RESYNC_ONES + 1);

    typedef struct packed {
        phase_e          phase;
        logic [4:0]      bitcnt;
        logic [4:0]      len;
        logic [2:0]      addr;
        logic            cont;
        logic [SHW-1:0]  shreg;
        logic            dout_bit;
        logic [15:0]     mode;
        logic [15:0]     cfg;
        logic [DW-1:0]   data;
        logic            sclk_prev;
    } st_t;

    st_t st_d, st_q;

    logic cs_s, sclk_s, din_s;
    logic rise, fall, active;
    logic rdy_n, read_done, resync_hit;
    logic [CW-1:0] ones_cnt;
    phase_e phase_q;

    sif_sync #(.N(3), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, din}), .q({cs_s, sclk_s, din_s})
    );

    assign active = !cs_s;
    assign rise   = active &&  sclk_s && !st_q.sclk_prev;
    assign fall   = active && !sclk_s &&  st_q.sclk_prev;

    sif_ready u_ready (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .pre_update(pre_update), .read_done(read_done), .rdy_n(rdy_n)
    );

    sif_resync #(.ONES(RESYNC_ONES)) u_resync (
        .clk(clk), .rst_n(rst_n), .active(active), .rise(rise),
        .bit_in(din_s), .hit(resync_hit), .cnt(ones_cnt)
    );

    function automatic logic [4:0] reg_len(input logic [2:0] a);
        case (a)
            A_MODE, A_CFG: return 5'd16;
            A_DATA:        return LEN_DATA;
            default:       return 5'd8;
        endcase
    endfunction

    function automatic logic [SHW-1:0] rd_word(input logic [2:0] a, input st_t s,
                                                input logic rdy);
        logic [SHW-1:0] w;
        w = '0;
        case (a)
            A_COMM: w[SHW-1 -: 8]  = {rdy, 6'b0, (DW == 24)};
            A_MODE: w[SHW-1 -: 16] = s.mode;
            A_CFG:  w[SHW-1 -: 16] = s.cfg;
            A_DATA: w[SHW-1 -: DW] = s.data;
            A_ID:   w[SHW-1 -: 8]  = ID_VALUE;
            default: w = '0;
        endcase
        return w;
    endfunction

    always_comb begin
        logic [7:0]  cmd;
        logic [15:0] word16;
        st_d      = st_q;
        read_done = 1'b0;
        st_d.sclk_prev = sclk_s;
        cmd    = {st_q.shreg[6:0], din_s};
        word16 = {st_q.shreg[14:0], din_s};

        if (conv_done) st_d.data = conv_result;

        if (!active) begin
            st_d.phase  = PH_CMD;
            st_d.bitcnt = '0;
        end else begin
            if (fall) begin
                if (st_q.phase == PH_RD) begin
                    st_d.dout_bit = st_q.shreg[SHW-1];
                    st_d.shreg    = st_q.shreg << 1;
                end else if (st_q.cont && st_q.phase == PH_CMD && !rdy_n) begin
                    st_d.shreg    = rd_word(A_DATA, st_q, rdy_n) << 1;
                    st_d.dout_bit = st_q.data[DW-1];
                    st_d.phase    = PH_RD;
                    st_d.addr     = A_DATA;
                    st_d.len      = LEN_DATA;
                    st_d.bitcnt   = '0;
                end
            end
            if (rise) begin
                case (st_q.phase)
                    PH_CMD: if (!st_q.cont) begin
                        st_d.shreg  = {st_q.shreg[SHW-2:0], din_s};
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (st_q.bitcnt == 5'd7) begin
                            st_d.bitcnt = '0;
                            if (!cmd[7] && cmd[1:0] == 2'b00) begin
                                st_d.addr = cmd[5:3];
                                st_d.len  = reg_len(cmd[5:3]);
                                if (cmd[6]) begin
                                    if (cmd[5:3] == A_DATA && cmd[2]) begin
                                        st_d.cont = 1'b1;
                                    end else begin
                                        st_d.phase = PH_RD;
                                        st_d.shreg = rd_word(cmd[5:3], st_q, rdy_n);
                                    end
                                end else if (cmd[5:3] != A_COMM) begin
                                    st_d.phase = PH_WR;
                                end
                            end
                        end
                    end
                    PH_WR: begin
                        st_d.shreg  = {st_q.shreg[SHW-2:0], din_s};
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (st_q.bitcnt == st_q.len - 1'b1) begin
                            st_d.phase  = PH_CMD;
                            st_d.bitcnt = '0;
                            if (st_q.addr == A_MODE) st_d.mode = word16;
                            if (st_q.addr == A_CFG)  st_d.cfg  = word16;
                        end
                    end
                    PH_RD: begin
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (st_q.bitcnt == st_q.len - 1'b1) begin
                            st_d.phase  = PH_CMD;
                            st_d.bitcnt = '0;
                            read_done   = (st_q.addr == A_DATA);
                        end
                    end
                    default: st_d.phase = PH_CMD;
                endcase
            end
            if (resync_hit) begin
                st_d.phase  = PH_CMD;
                st_d.bitcnt = '0;
                st_d.cont   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.phase     <= PH_CMD;
            st_q.mode      <= MODE_RST;
            st_q.cfg       <= CFG_RST;
            st_q.dout_bit  <= 1'b1;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q   = st_q.phase;
    assign dout_oe   = active;
    assign dout      = (st_q.phase == PH_RD) ? st_q.dout_bit : rdy_n;
    assign mode_word = st_q.mode;
    assign cfg_word  = st_q.cfg;
endmodule

// File: rtl/adc_serial_if_checks.sv
module adc_serial_if_checks
    import adc_sif_pkg::*;
#(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dout_oe,
    input logic          conv_done,
    input logic          pre_update,
    input logic          read_done,
    input logic          rdy_n,
    input logic [CW-1:0] ones_cnt,
    input phase_e        phase
);
    // R1: a deselected port is waiting for a command on the next cycle
    a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |=> phase == PH_CMD);

    // R6: a result strobe makes the flag 0 on the next cycle
    a_r6_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !rdy_n);

    // R6: the flag only falls after a result strobe
    a_r6_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(conv_done));

    // R7: a warning strobe alone raises the flag
    a_r7_warning_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_update && !conv_done) |=> rdy_n);

    // R8: the flag only rises after a warning or a completed result read
    a_r8_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(pre_update || read_done));

    // R11: the ones counter never reaches its limit
    a_r11_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt < CW'(RESYNC_ONES));
endmodule

bind adc_serial_if adc_serial_if_checks #(.CW(CW)) u_checks (
    .clk(clk), .rst_n(rst_n), .dout_oe(dout_oe), .conv_done(conv_done),
    .pre_update(pre_update), .read_done(read_done), .rdy_n(rdy_n),
    .ones_cnt(ones_cnt), .phase(phase_q)
);

// File: tb/adc_serial_if_tb.sv
`timescale 1ns/1ps
module adc_serial_if_tb_top;
    localparam int DW = 16;
    localparam logic [7:0] IDV = 8'hC3;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic conv_done = 1'b0, pre_update = 1'b0;
    logic [DW-1:0] conv_result = '0;
    logic dout, dout_oe;
    logic [15:0] mode_word, cfg_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_serial_if #(.DW(DW), .ID_VALUE(IDV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_done(conv_done), .conv_result(conv_result), .pre_update(pre_update),
        .dout(dout), .dout_oe(dout_oe), .mode_word(mode_word), .cfg_word(cfg_word)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        din  = b;
        wait_clk(HALF);
        o = dout;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send(input int n, input logic [31:0] v);
        logic o;
        for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], o);
    endtask

    task automatic recv(input int n, output logic [31:0] v);
        logic o;
        v = '0;
        for (int i = n - 1; i >= 0; i--) begin
            xfer_bit(1'b0, o);
            v[i] = o;
        end
    endtask

    function automatic logic [7:0] cmdb(input logic rd, input logic [2:0] a,
                                        input logic c);
        return {1'b0, rd, a, c, 2'b00};
    endfunction

    task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] v);
        send(8, {24'b0, cmdb(1'b1, a, 1'b0)});
        recv(n, v);
    endtask

    task automatic wr_reg(input logic [2:0] a, input int n, input logic [31:0] v);
        send(8, {24'b0, cmdb(1'b0, a, 1'b0)});
        send(n, v);
    endtask

    task automatic strobe_result(input logic [DW-1:0] v);
        @(negedge clk);
        conv_done = 1'b1;
        conv_result = v;
        @(negedge clk);
        conv_done = 1'b0;
        wait_clk(3);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [15:0] exp16;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: deselected output is disabled
        check("R1 oe while deselected", dout_oe, 0);
        cs_n = 1'b0;
        wait_clk(5);
        check("R1 oe while selected", dout_oe, 1);
        check("R6 no result: flag high", dout, 1);
        check("R5 mode reset", mode_word, 16'h000A);

        // R4 identity and status
        rd_reg(3'd4, 8, v);
        check("R4 identity read", v, IDV);
        rd_reg(3'd0, 8, v);
        check("R9 status, no result, DW16", v, 8'h80);
        rd_reg(3'd6, 8, v);
        check("R4 unused address reads zero", v, 0);

        // R5 mode and configuration sweep
        for (int i = 0; i < 16; i++) begin
            exp16 = 16'((i * 16'h1111) ^ 16'hA5C3);
            wr_reg(3'd1, 16, {16'b0, exp16});
            check("R5 mode port", mode_word, exp16);
            check("R5 mode rate field bits 3:0", mode_word[3:0], exp16[3:0]);
            rd_reg(3'd1, 16, v);
            check("R5 mode readback", v, exp16);
            wr_reg(3'd2, 16, {16'b0, ~exp16});
            rd_reg(3'd2, 16, v);
            check("R5 config readback", v, 16'(~exp16));
            check("R5 config port", cfg_word, 16'(~exp16));
        end

        // R5 read-only writes discarded
        wr_reg(3'd4, 8, 32'h11);
        rd_reg(3'd4, 8, v);
        check("R5 identity write discarded", v, IDV);
        strobe_result(16'h1234);
        rd_reg(3'd3, 16, v);
        check("R12 result readback", v, 16'h1234);
        wr_reg(3'd3, 16, 32'hBEEF);
        rd_reg(3'd3, 16, v);
        check("R5 result write discarded", v, 16'h1234);

        // R4 write to address 0: no data phase, next byte is a command
        send(8, {24'b0, cmdb(1'b0, 3'd0, 1'b0)});
        rd_reg(3'd4, 8, v);
        check("R4 address 0 write has no data phase", v, IDV);

        // R2 invalid command byte ignored
        send(8, 32'hA0);
        rd_reg(3'd4, 8, v);
        check("R2 invalid byte ignored", v, IDV);
        send(8, 32'h61);
        rd_reg(3'd4, 8, v);
        check("R2 low bits set ignored", v, IDV);

        // R6/R8/R12 result sweep, with re-read
        for (int i = 0; i < 20; i++) begin
            case (i)
                0: exp16 = 16'h0000;
                1: exp16 = 16'hFFFF;
                2: exp16 = 16'h8000;
                3: exp16 = 16'h7FFF;
                default: exp16 = 16'(i * 16'h1357 + 16'h0F0F);
            endcase
            strobe_result(exp16);
            check("R6 flag low after result", dout, 0);
            rd_reg(3'd0, 8, v);
            check("R9 status with unread result", v, 8'h00);
            rd_reg(3'd3, 16, v);
            check("R3 R12 result bits MSB first", v, exp16);
            wait_clk(3);
            check("R8 flag high after read", dout, 1);
            rd_reg(3'd3, 16, v);
            check("R8 re-read same result", v, exp16);
        end

        // R7 warning strobe clears the flag
        strobe_result(16'h4321);
        @(negedge clk); pre_update = 1'b1;
        @(negedge clk); pre_update = 1'b0;
        wait_clk(2);
        check("R7 flag high after warning", dout, 1);
        @(negedge clk); pre_update = 1'b1; conv_done = 1'b1; conv_result = 16'h5555;
        @(negedge clk); pre_update = 1'b0; conv_done = 1'b0;
        wait_clk(2);
        check("R7 result wins over warning", dout, 0);
        rd_reg(3'd3, 16, v);
        check("R7 result after tie", v, 16'h5555);

        // R10 continuous read
        send(8, {24'b0, cmdb(1'b1, 3'd3, 1'b1)});
        for (int i = 0; i < 4; i++) begin
            exp16 = 16'(16'h9000 + i * 16'h0321);
            strobe_result(exp16);
            recv(16, v);
            check("R10 continuous word", v, exp16);
            wait_clk(3);
            check("R10 flag high after word", dout, 1);
            recv(16, v);
            check("R10 no second delivery", v, 16'hFFFF);
        end

        // R11 resync leaves continuous read
        send(32, 32'hFFFF_FFFF);
        rd_reg(3'd4, 8, v);
        check("R11 command decoded after ones", v, IDV);
        rd_reg(3'd1, 16, v);
        check("R11 registers unchanged", v, 16'((15 * 16'h1111) ^ 16'hA5C3));

        // R1 abort by raising select
        send(4, 32'h6);
        @(negedge clk); cs_n = 1'b1;
        wait_clk(6);
        check("R1 oe low on abort", dout_oe, 0);
        cs_n = 1'b0;
        wait_clk(6);
        rd_reg(3'd4, 8, v);
        check("R1 fresh frame after abort", v, IDV);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule